// File: doc/BRIEF.md
# Per-Tenant Match Key Extractor

This block sits at the front of one match stage. It receives a packet header vector (PHV) and builds a 193-bit lookup key and a matching mask for the lookup that follows it. The PHV holds eight 6-byte, eight 4-byte and eight 2-byte header containers above a 256-bit metadata field. The tenant's VLAN ID sits in metadata bits [140:129]. Its low bits select one entry in each of two small configuration RAMs.

The instruction RAM entry names two containers of each size to place in the key. It also defines one comparison between two operands. Each operand is either a PHV container or an 8-bit immediate. The single result bit of that comparison is appended to the key, so later actions can be made conditional on it. The mask RAM entry is applied to the key with a bitwise AND, and is also passed downstream so the lookup can ignore the cleared bits.

Both RAMs have their own write port, so software can reconfigure one tenant while traffic for other tenants keeps flowing. The PHV travels alongside the key and leaves on the same cycle. One valid bit covers all three outputs.

Top module: `kx_key_extractor`

## Requirements
- R1: An input accepted with `in_valid` high produces `out_valid` high exactly two clock cycles later, and on that cycle `phv_out` equals the accepted PHV. A cycle without `in_valid` gives `out_valid` low two cycles later.
- R2: The configuration entry used for a PHV is the one addressed by PHV bits [132:129], which are the low four bits of the VLAN ID. Bits [140:133] do not affect the result.
- R3: Container layout: 2-byte container i is PHV[256+16i +: 16], 4-byte container i is PHV[384+32i +: 32], and 6-byte container i is PHV[640+48i +: 48]. Before masking, the key is, from MSB to LSB: 6B slot A [192:145], 6B slot B [144:97], 4B slot A [96:65], 4B slot B [64:33], 2B slot A [32:17], 2B slot B [16:1], comparison result [0].
- R4: Instruction fields, from MSB to LSB: 6B A index [37:35], 6B B index [34:32], 4B A index [31:29], 4B B index [28:26], 2B A index [25:23], 2B B index [22:20], opcode [19:18], left operand [17:9], right operand [8:0].
- R5: The opcode selects the comparison of left against right: 00 is greater-than, 01 is greater-or-equal, 11 is equal, and 10 always yields 0.
- R6: Operand encoding: if bit 8 is set, bits [7:0] are an immediate. Otherwise bits [7:5] give a container index and bits [4:3] give its type: 01 for 2B, 10 for 4B, 11 for 6B, and 00 for a constant zero. Operands are compared as unsigned values, zero-extended to 48 bits.
- R7: `key_out` equals the unmasked key ANDed with the selected mask entry, and `mask_out` equals that mask entry.
- R8: A RAM write takes effect at the clock edge. A PHV accepted on the same edge as a write to the entry it addresses uses the entry's old contents, and the next PHV uses the new contents.
- R9: After synchronous reset, `out_valid`, `key_out`, `mask_out` and `phv_out` are all zero.
- R10: On cycles when no new result arrives, `key_out`, `mask_out` and `phv_out` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input PHV is valid this cycle |
| in_phv | input | 1024 | Packet header vector |
| instr_we | input | 1 | Instruction RAM write enable |
| instr_waddr | input | 4 | Instruction RAM write address |
| instr_wdata | input | 38 | Instruction RAM write data |
| mask_we | input | 1 | Mask RAM write enable |
| mask_waddr | input | 4 | Mask RAM write address |
| mask_wdata | input | 193 | Mask RAM write data |
| out_valid | output | 1 | Key, mask and PHV outputs are new this cycle |
| key_out | output | 193 | Masked lookup key |
| mask_out | output | 193 | Mask applied to the key |
| phv_out | output | 1024 | PHV delayed to line up with the key |

## Verification
The hardest case to reach from the ports is a comparison that comes out true. Random 48-bit containers almost never equal an immediate or another container. The stimulus therefore plants matching small values in chosen containers and runs directed instructions for every opcode at the equal, just-above and zero-extension boundaries. A second hard case is a write that lands on the same edge as a PHV reading the same entry. The bench steers a valid PHV to the entry being rewritten and then sends a follow-up PHV to observe the new contents. Random traffic mixes writes to random entries with PHVs whose VLAN upper bits vary, so that entry selection and hold behaviour are exercised continuously.

// File: rtl/kx_pkg.sv
package kx_pkg;

    localparam int NCONT   = 8;
    localparam int IDX_W   = 3;
    localparam int W2      = 16;
    localparam int W4      = 32;
    localparam int W6      = 48;
    localparam int META_W  = 256;
    localparam int OPND_W  = 9;
    localparam int PHV_W   = META_W + NCONT * (W2 + W4 + W6);
    localparam int OFF2    = META_W;
    localparam int OFF4    = OFF2 + NCONT * W2;
    localparam int OFF6    = OFF4 + NCONT * W4;
    localparam int KEY_W   = 2 * (W6 + W4 + W2) + 1;
    localparam int INSTR_W = 6 * IDX_W + 2 + 2 * OPND_W;

    typedef enum logic [1:0] {
        CMP_GT   = 2'b00,
        CMP_GE   = 2'b01,
        CMP_NONE = 2'b10,
        CMP_EQ   = 2'b11
    } cmp_op_e;

    typedef enum logic [1:0] {
        CT_ZERO = 2'b00,
        CT_2B   = 2'b01,
        CT_4B   = 2'b10,
        CT_6B   = 2'b11
    } ctype_e;

    typedef struct packed {
        logic [IDX_W-1:0]  sel6_a;
        logic [IDX_W-1:0]  sel6_b;
        logic [IDX_W-1:0]  sel4_a;
        logic [IDX_W-1:0]  sel4_b;
        logic [IDX_W-1:0]  sel2_a;
        logic [IDX_W-1:0]  sel2_b;
        cmp_op_e           op;
        logic [OPND_W-1:0] opnd_l;
        logic [OPND_W-1:0] opnd_r;
    } kx_instr_t;

    typedef struct packed {
        logic [W6-1:0] c6_a;
        logic [W6-1:0] c6_b;
        logic [W4-1:0] c4_a;
        logic [W4-1:0] c4_b;
        logic [W2-1:0] c2_a;
        logic [W2-1:0] c2_b;
        logic          cond;
    } kx_key_t;

    // Resolve one comparator operand to a zero-extended 48-bit value.
    function automatic logic [W6-1:0] kx_operand(
        input logic [OPND_W-1:0]   o,
        input logic [NCONT*W6-1:0] f6,
        input logic [NCONT*W4-1:0] f4,
        input logic [NCONT*W2-1:0] f2
    );
        logic [W6-1:0] v;
        v = '0;
        if (o[8]) begin
            v[7:0] = o[7:0];
        end else begin
            case (ctype_e'(o[4:3]))
                CT_2B:   v[W2-1:0] = f2[o[7:5]*W2 +: W2];
                CT_4B:   v[W4-1:0] = f4[o[7:5]*W4 +: W4];
                CT_6B:   v         = f6[o[7:5]*W6 +: W6];
                default: v         = '0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/kx_cfg_ram.sv
module kx_cfg_ram #(
    parameter int WIDTH = 8,
    parameter int AW    = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read-first: a read on the write edge returns the old word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/kx_pick.sv
module kx_pick #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N*W-1:0] flat,
    input  logic [IW-1:0]  sel,
    output logic [W-1:0]   val
);

    assign val = flat[sel*W +: W];

endmodule

// File: rtl/kx_compare.sv
module kx_compare
    import kx_pkg::*;
(
    input  logic [NCONT*W6-1:0] f6,
    input  logic [NCONT*W4-1:0] f4,
    input  logic [NCONT*W2-1:0] f2,
    input  cmp_op_e             op,
    input  logic [OPND_W-1:0]   opnd_l,
    input  logic [OPND_W-1:0]   opnd_r,
    output logic                result
);

    logic [W6-1:0] lval;
    logic [W6-1:0] rval;

    always_comb begin
        lval = kx_operand(opnd_l, f6, f4, f2);
        rval = kx_operand(opnd_r, f6, f4, f2);
        case (op)
            CMP_GT:  result = (lval >  rval);
            CMP_GE:  result = (lval >= rval);
            CMP_EQ:  result = (lval == rval);
            default: result = 1'b0;
        endcase
    end

endmodule

// File: rtl/kx_key_extractor.sv
module kx_key_extractor
    import kx_pkg::*;
#(
    parameter int VID_LSB = 129,
    parameter int CFG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PHV_W-1:0]   in_phv,
    input  logic               instr_we,
    input  logic [CFG_AW-1:0]  instr_waddr,
    input  logic [INSTR_W-1:0] instr_wdata,
    input  logic               mask_we,
    input  logic [CFG_AW-1:0]  mask_waddr,
    input  logic [KEY_W-1:0]   mask_wdata,
    output logic               out_valid,
    output logic [KEY_W-1:0]   key_out,
    output logic [KEY_W-1:0]   mask_out,
    output logic [PHV_W-1:0]   phv_out
);

    // Stage 0 -> 1: configuration read, PHV register
    logic [CFG_AW-1:0]  rd_addr;
    logic [INSTR_W-1:0] instr_rd;
    logic [KEY_W-1:0]   mask_rd;
    logic               s1_valid;
    logic [PHV_W-1:0]   s1_phv;

    assign rd_addr = in_phv[VID_LSB +: CFG_AW];

    kx_cfg_ram #(.WIDTH(INSTR_W), .AW(CFG_AW)) u_instr_ram (
        .clk   (clk),
        .we    (instr_we),
        .waddr (instr_waddr),
        .wdata (instr_wdata),
        .re    (in_valid),
        .raddr (rd_addr),
        .rdata (instr_rd)
    );

    kx_cfg_ram #(.WIDTH(KEY_W), .AW(CFG_AW)) u_mask_ram (
        .clk   (clk),
        .we    (mask_we),
        .waddr (mask_waddr),
        .wdata (mask_wdata),
        .re    (in_valid),
        .raddr (rd_addr),
        .rdata (mask_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_phv   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_phv <= in_phv;
        end
    end

    // Stage 1: container selection and comparison
    kx_instr_t          s1_instr;
    logic [1:0]         s1_op;
    logic [NCONT*W6-1:0] f6;
    logic [NCONT*W4-1:0] f4;
    logic [NCONT*W2-1:0] f2;
    logic [IDX_W-1:0]   sel6 [2];
    logic [IDX_W-1:0]   sel4 [2];
    logic [IDX_W-1:0]   sel2 [2];
    logic [W6-1:0]      v6 [2];
    logic [W4-1:0]      v4 [2];
    logic [W2-1:0]      v2 [2];
    logic               cmp_bit;
    kx_key_t            raw_key;

    assign s1_instr = kx_instr_t'(instr_rd);
    assign s1_op    = s1_instr.op;
    assign f6 = s1_phv[OFF6 +: NCONT*W6];
    assign f4 = s1_phv[OFF4 +: NCONT*W4];
    assign f2 = s1_phv[OFF2 +: NCONT*W2];

    assign sel6[0] = s1_instr.sel6_a;
    assign sel6[1] = s1_instr.sel6_b;
    assign sel4[0] = s1_instr.sel4_a;
    assign sel4[1] = s1_instr.sel4_b;
    assign sel2[0] = s1_instr.sel2_a;
    assign sel2[1] = s1_instr.sel2_b;

    for (genvar g = 0; g < 2; g++) begin : g_slot
        kx_pick #(.W(W6), .N(NCONT), .IW(IDX_W)) u_p6 (
            .flat(f6), .sel(sel6[g]), .val(v6[g]));
        kx_pick #(.W(W4), .N(NCONT), .IW(IDX_W)) u_p4 (
            .flat(f4), .sel(sel4[g]), .val(v4[g]));
        kx_pick #(.W(W2), .N(NCONT), .IW(IDX_W)) u_p2 (
            .flat(f2), .sel(sel2[g]), .val(v2[g]));
    end

    kx_compare u_cmp (
        .f6     (f6),
        .f4     (f4),
        .f2     (f2),
        .op     (s1_instr.op),
        .opnd_l (s1_instr.opnd_l),
        .opnd_r (s1_instr.opnd_r),
        .result (cmp_bit)
    );

    always_comb begin
        raw_key.c6_a = v6[0];
        raw_key.c6_b = v6[1];
        raw_key.c4_a = v4[0];
        raw_key.c4_b = v4[1];
        raw_key.c2_a = v2[0];
        raw_key.c2_b = v2[1];
        raw_key.cond = cmp_bit;
    end

    // Stage 1 -> 2: masked key out, held between results
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            key_out   <= '0;
            mask_out  <= '0;
            phv_out   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                key_out  <= KEY_W'(raw_key) & mask_rd;
                mask_out <= mask_rd;
                phv_out  <= s1_phv;
            end
        end
    end

endmodule

// File: rtl/kx_key_extractor_chk.sv
module kx_key_extractor_chk
    import kx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PHV_W-1:0] in_phv,
    input logic             s1_valid,
    input logic [1:0]       s1_op,
    input logic             cmp_bit,
    input logic             out_valid,
    input logic [KEY_W-1:0] key_out,
    input logic [KEY_W-1:0] mask_out,
    input logic [PHV_W-1:0] phv_out
);

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_phv_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (phv_out == $past(in_phv, 2)));

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 ($stable(key_out) && $stable(mask_out) && $stable(phv_out)));

    assert_never_opcode_R5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_op == 2'b10) |-> !cmp_bit);

endmodule

bind kx_key_extractor kx_key_extractor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_phv    (in_phv),
    .s1_valid  (s1_valid),
    .s1_op     (s1_op),
    .cmp_bit   (cmp_bit),
    .out_valid (out_valid),
    .key_out   (key_out),
    .mask_out  (mask_out),
    .phv_out   (phv_out)
);

// File: tb/sim_kx_key_extractor.sv
module sim_kx_key_extractor;

    localparam int PW = 1024;
    localparam int KW = 193;
    localparam int IW = 38;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_phv = '0;
    logic          instr_we = 1'b0;
    logic [3:0]    instr_waddr = '0;
    logic [IW-1:0] instr_wdata = '0;
    logic          mask_we = 1'b0;
    logic [3:0]    mask_waddr = '0;
    logic [KW-1:0] mask_wdata = '0;
    logic          out_valid;
    logic [KW-1:0] key_out;
    logic [KW-1:0] mask_out;
    logic [PW-1:0] phv_out;

    always #2 clk = ~clk;

    kx_key_extractor u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_phv(in_phv),
        .instr_we(instr_we), .instr_waddr(instr_waddr), .instr_wdata(instr_wdata),
        .mask_we(mask_we), .mask_waddr(mask_waddr), .mask_wdata(mask_wdata),
        .out_valid(out_valid), .key_out(key_out), .mask_out(mask_out), .phv_out(phv_out)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [IW-1:0] sh_instr [16];
    logic [KW-1:0] sh_mask [16];
    logic          h_valid = 0;
    logic [KW-1:0] h_key = '0, h_mask = '0;
    logic [PW-1:0] h_phv = '0;
    logic          e0_v = 0, e1_v = 0;
    logic [KW-1:0] e0_k = '0, e1_k = '0, e0_m = '0, e1_m = '0;
    logic [PW-1:0] e0_p = '0, e1_p = '0;
    string         e0_t = "", e1_t = "";

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] opv(input logic [8:0] o, input logic [PW-1:0] p);
        int idx;
        idx = int'(o[7:5]);
        if (o[8]) return {40'd0, o[7:0]};
        if (o[4:3] == 2'b01) return {32'd0, p[256 + 16*idx +: 16]};
        if (o[4:3] == 2'b10) return {16'd0, p[384 + 32*idx +: 32]};
        if (o[4:3] == 2'b11) return p[640 + 48*idx +: 48];
        return 48'd0;
    endfunction

    function automatic logic [KW-1:0] model(input logic [PW-1:0] p, input logic [IW-1:0] ins,
                                            input logic [KW-1:0] m);
        logic [47:0] l, r;
        logic c;
        logic [KW-1:0] k;
        l = opv(ins[17:9], p);
        r = opv(ins[8:0], p);
        case (ins[19:18])
            2'b00: c = l > r;
            2'b01: c = l >= r;
            2'b11: c = l == r;
            default: c = 1'b0;
        endcase
        k = {p[640 + 48*int'(ins[37:35]) +: 48], p[640 + 48*int'(ins[34:32]) +: 48],
             p[384 + 32*int'(ins[31:29]) +: 32], p[384 + 32*int'(ins[28:26]) +: 32],
             p[256 + 16*int'(ins[25:23]) +: 16], p[256 + 16*int'(ins[22:20]) +: 16], c};
        return k & m;
    endfunction

    function automatic logic [PW-1:0] rnd_phv();
        logic [PW-1:0] p;
        for (int i = 0; i < PW/32; i++) p[i*32 +: 32] = $urandom;
        if ($urandom_range(3) == 0)
            for (int i = 0; i < 8; i++) p[640 + 48*i +: 48] = 48'($urandom_range(255));
        return p;
    endfunction

    function automatic logic [KW-1:0] rnd_mask();
        logic [KW-1:0] m;
        for (int i = 0; i < 7; i++) m[i*32 +: 32] = $urandom;
        if ($urandom_range(1) == 0) m = '1;
        return m;
    endfunction

    function automatic logic [IW-1:0] rnd_instr();
        return {$urandom, $urandom}[IW-1:0];
    endfunction

    function automatic logic [8:0] imm(input logic [7:0] v);
        return {1'b1, v};
    endfunction

    function automatic logic [8:0] cref(input logic [2:0] idx, input logic [1:0] ty);
        return {1'b0, idx, ty, 3'b000};
    endfunction

    function automatic logic [PW-1:0] with_vid(input logic [PW-1:0] p, input logic [11:0] vid);
        logic [PW-1:0] q;
        q = p;
        q[140:129] = vid;
        return q;
    endfunction

    task automatic step(input logic v, input logic [PW-1:0] p,
                        input logic iwe, input logic [3:0] ia, input logic [IW-1:0] id,
                        input logic mwe, input logic [3:0] ma, input logic [KW-1:0] md,
                        input string tag);
        int a;
        @(negedge clk);
        chk("R1 out_valid", PW'(out_valid), PW'(e1_v));
        chk(e1_v ? "R1 phv_out" : "R10 phv_out hold", phv_out, e1_p);
        chk(e1_v ? e1_t : "R10 key_out hold", PW'(key_out), PW'(e1_k));
        chk(e1_v ? "R7 mask_out" : "R10 mask_out hold", PW'(mask_out), PW'(e1_m));
        e1_v = e0_v; e1_k = e0_k; e1_m = e0_m; e1_p = e0_p; e1_t = e0_t;
        in_valid = v; in_phv = p;
        instr_we = iwe; instr_waddr = ia; instr_wdata = id;
        mask_we = mwe; mask_waddr = ma; mask_wdata = md;
        a = int'(p[132:129]);
        if (v) begin
            h_key = model(p, sh_instr[a], sh_mask[a]);
            h_mask = sh_mask[a];
            h_phv = p;
        end
        e0_v = v; e0_k = h_key; e0_m = h_mask; e0_p = h_phv; e0_t = tag;
        if (iwe) sh_instr[ia] = id;
        if (mwe) sh_mask[ma] = md;
    endtask

    task automatic idle();
        step(0, '0, 0, '0, '0, 0, '0, '0, "");
    endtask

    initial begin
        logic [PW-1:0] p;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        chk("R9 out_valid reset", PW'(out_valid), '0);
        chk("R9 key_out reset", PW'(key_out), '0);
        chk("R9 mask_out reset", PW'(mask_out), '0);
        chk("R9 phv_out reset", phv_out, '0);

        for (int i = 0; i < 16; i++)
            step(0, '0, 1, 4'(i), rnd_instr(), 1, 4'(i), rnd_mask(), "");

        // R5/R6 directed on entry 3, with upper VLAN bits nonzero (R2)
        step(0, '0, 1, 4'd3, {18'o123456, 2'b11, cref(3'd2, 2'b11), imm(8'h5A)},
             1, 4'd3, '1, "");
        p = '0; p[640 + 48*2 +: 48] = 48'h5A;
        step(1, with_vid(p, 12'hA53), 0, '0, '0, 0, '0, '0, "R5 R6 R2 eq imm true");
        p[640 + 48*2 +: 48] = 48'h15A;
        step(1, with_vid(p, 12'h003), 0, '0, '0, 0, '0, '0, "R6 zero-extend eq false");
        // GE with 4B vs 2B equal, then GT equal
        step(0, '0, 1, 4'd3, {18'o765432, 2'b01, cref(3'd1, 2'b10), cref(3'd4, 2'b01)},
             0, '0, '0, "");
        p = rnd_phv(); p[384 + 32*1 +: 32] = 32'h0000_BEEF; p[256 + 16*4 +: 16] = 16'hBEEF;
        step(1, with_vid(p, 12'h7F3), 0, '0, '0, 0, '0, '0, "R5 R3 R4 ge equal");
        step(1, with_vid(p, 12'h013), 1, 4'd3,
             {18'o001122, 2'b00, cref(3'd1, 2'b10), cref(3'd4, 2'b01)}, 0, '0, '0,
             "R8 read old during write");
        step(1, with_vid(p, 12'h023), 1, 4'd3,
             {18'o334455, 2'b10, cref(3'd1, 2'b10), cref(3'd4, 2'b01)}, 0, '0, '0,
             "R8 R5 gt equal after write");
        step(1, with_vid(p, 12'h033), 1, 4'd3,
             {18'o667700, 2'b11, cref(3'd0, 2'b00), imm(8'h00)}, 1, 4'd3, rnd_mask(),
             "R5 never opcode false");
        step(1, with_vid(p, 12'h043), 0, '0, '0, 0, '0, '0, "R6 R7 type zero eq imm zero");
        idle(); idle(); idle();

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic v, iw, mw;
            v = ($urandom_range(3) != 0);
            iw = ($urandom_range(4) == 0);
            mw = ($urandom_range(4) == 0);
            p = rnd_phv();
            if ($urandom_range(3) == 0) p[132:129] = 4'd3;
            step(v, p, iw, 4'($urandom_range(15)), rnd_instr(),
                 mw, 4'($urandom_range(15)), rnd_mask(), "R2 R3 R4 R5 R6 R7 R8 random key");
        end
        idle(); idle(); idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule